// File: doc/BRIEF.md
# Extension Capability Register

This block holds the machine-level word that reports which instruction-set extensions a core implements. Each of the low 26 bits stands for one extension letter, with A at bit 0 and Z at bit 25. The top two bits report the base integer width. One parameter mask fixes which letters exist in this build. A second mask fixes which of those letters software may turn on and off.

Access is through a single-cycle register port. A read is combinational from the stored word. A write is accepted on every clock edge where `wr_en` is high, so there is no back-pressure and no handshake.

Every write passes through a legalization step before it is stored:
- Letters that are absent or not switchable keep their value.
- The reduced-register base bit always mirrors the full base bit.
- The memory-ordering bit is a build-time constant.
- A write that leaves an extension on while the extension it builds on is off clears both.

A build parameter can instead force the whole word to read as zero.

Top module: `isa_caps_reg`

## Requirements
- R1: After reset, every implemented letter reads 1, E (bit 4) reads the inverse of I (bit 8), bit 19 reads `ORDER_TSO`, and bits [XLEN-1:XLEN-2] hold the width code (1 for XLEN=32). Bits [XLEN-3:26] read 0.
- R2: The width code in bits [XLEN-1:XLEN-2] and the zero bits [XLEN-3:26] never change, whatever is written.
- R3: Reserved letters 17 and 22, and every letter outside `IMPL_MASK`, read 0 even when written with 1.
- R4: Bit 19 (total-store-ordering flag) always reads `ORDER_TSO`, and writes to it have no effect.
- R5: Bit 4 (E) is read-only and always reads the inverse of bit 8 (I) when both are implemented. Writes to bit 4 are ignored.
- R6: When both base letters E and I are implemented, writing I=0 selects the reduced base, so E then reads 1. Writing I=1 returns E to 0.
- R7: An implemented letter outside `SWITCH_MASK` keeps its reset value across writes.
- R8: A switchable letter takes the legalized written value on the clock edge where `wr_en` is 1. With `wr_en` at 0, the stored word does not change, whatever `wr_data` holds.
- R9: A write that leaves D (bit 3) at 1 with F (bit 5) at 0 stores both as 0.
- R10: A write that leaves Q (bit 16) at 1 with D at 0 stores both as 0. This includes the case where D was cleared by the rule in R9.
- R11: With `HARDWIRED_ZERO`=1, `rd_data` is all zeros at all times, and writes have no visible effect.
- R12: A write is visible on `rd_data` in the cycle right after its clock edge, so writes issued on consecutive cycles read back one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | XLEN | Value offered for the write |
| rd_data | output | XLEN | Current legalized word, combinational from the stored value |

## Verification
The bench builds two copies of the block on the same inputs. The first has `IMPL_MASK`=26'h057113D, `SWITCH_MASK`=26'h01F013C and `ORDER_TSO`=1. The second has the same masks with `HARDWIRED_ZERO`=1. The first build declares both reserved letters as implemented, and its switch mask includes the E bit, the ordering bit and a reserved letter. This lets the bench see that those bits stay fixed no matter what the masks claim. Letters A and M are implemented but not switchable, which exercises the keep-on-write path. Because both base letters are present, the I-to-E selection and the chained clearing of Q after D after F can all be driven from the write port.

// File: rtl/isa_caps_pkg.sv
package isa_caps_pkg;
  localparam int LETTERS   = 26;
  localparam int POS_D     = 3;
  localparam int POS_E     = 4;
  localparam int POS_F     = 5;
  localparam int POS_I     = 8;
  localparam int POS_Q     = 16;
  localparam int POS_RSV_A = 17;
  localparam int POS_ORDER = 19;
  localparam int POS_RSV_B = 22;
  localparam int DEP_PAIRS = 2;

  typedef logic [LETTERS-1:0] letters_t;

  localparam letters_t RSVD_MASK = (letters_t'(1) << POS_RSV_A) | (letters_t'(1) << POS_RSV_B);
  localparam letters_t ORDER_BIT = letters_t'(1) << POS_ORDER;
  localparam letters_t E_BIT     = letters_t'(1) << POS_E;
  localparam letters_t I_BIT     = letters_t'(1) << POS_I;

  // Dependency pairs, resolved in ascending order so a cleared parent
  // propagates to the child of the next pair.
  function automatic int dep_child(input int k);
    return (k == 0) ? POS_D : POS_Q;
  endfunction

  function automatic int dep_parent(input int k);
    return (k == 0) ? POS_F : POS_D;
  endfunction

  function automatic int width_code(input int xlen);
    return (xlen == 32) ? 1 : ((xlen == 64) ? 2 : 3);
  endfunction
endpackage

// File: rtl/isa_caps_merge.sv
module isa_caps_merge
  import isa_caps_pkg::*;
#(
  parameter letters_t SW_EFF = '0
) (
  input  letters_t cur,
  input  letters_t wdata,
  input  logic     wr_en,
  output letters_t merged
);
  logic unused_wr;
  assign unused_wr = ^(wdata & ~SW_EFF);

  for (genvar b = 0; b < LETTERS; b++) begin : g_bit
    if (SW_EFF[b]) begin : g_sw
      assign merged[b] = wr_en ? wdata[b] : cur[b];
    end else begin : g_keep
      assign merged[b] = cur[b];
    end
  end
endmodule

// File: rtl/isa_caps_fix.sv
module isa_caps_fix
  import isa_caps_pkg::*;
#(
  parameter letters_t IMPL_EFF  = '0,
  parameter bit       ORDER_TSO = 1'b0
) (
  input  letters_t raw,
  output letters_t fixed
);
  letters_t work;

  always_comb begin
    work = raw & IMPL_EFF;
    work[POS_E] = IMPL_EFF[POS_E] & ~work[POS_I];
    for (int k = 0; k < DEP_PAIRS; k++) begin
      if (work[dep_child(k)] && !work[dep_parent(k)]) begin
        work[dep_child(k)] = 1'b0;
      end
    end
    work[POS_ORDER] = ORDER_TSO;
  end

  assign fixed = work;
endmodule

// File: rtl/isa_caps_store.sv
module isa_caps_store
  import isa_caps_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  letters_t rst_val,
  input  letters_t d,
  output letters_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= rst_val;
    else        q <= d;
  end
endmodule

// File: rtl/isa_caps_reg.sv
module isa_caps_reg
  import isa_caps_pkg::*;
#(
  parameter int          XLEN           = 32,
  parameter logic [25:0] IMPL_MASK      = 26'h0141129,
  parameter logic [25:0] SWITCH_MASK    = 26'h0141128,
  parameter bit          ORDER_TSO      = 1'b0,
  parameter bit          HARDWIRED_ZERO = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] rd_data
);
  localparam int       CODE_W     = 2;
  localparam int       MID_W      = XLEN - CODE_W - LETTERS;
  localparam letters_t IMPL_EFF   = IMPL_MASK & ~RSVD_MASK & ~ORDER_BIT;
  localparam bit       BOTH_BASES = IMPL_EFF[POS_I] & IMPL_EFF[POS_E];
  localparam letters_t SW_EFF     = SWITCH_MASK & IMPL_EFF & ~E_BIT
                                    & ~(BOTH_BASES ? letters_t'(0) : I_BIT);
  localparam logic [CODE_W-1:0] CODE = CODE_W'(width_code(XLEN));

  letters_t stored, merged, legal, rst_val;
  logic     unused_hi;

  assign unused_hi = ^wr_data[XLEN-1:LETTERS];

  isa_caps_fix #(.IMPL_EFF(IMPL_EFF), .ORDER_TSO(ORDER_TSO)) i_rst_fix (
    .raw   (IMPL_EFF),
    .fixed (rst_val)
  );

  isa_caps_merge #(.SW_EFF(SW_EFF)) i_merge (
    .cur    (stored),
    .wdata  (wr_data[LETTERS-1:0]),
    .wr_en  (wr_en),
    .merged (merged)
  );

  isa_caps_fix #(.IMPL_EFF(IMPL_EFF), .ORDER_TSO(ORDER_TSO)) i_wr_fix (
    .raw   (merged),
    .fixed (legal)
  );

  isa_caps_store i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_val (rst_val),
    .d       (legal),
    .q       (stored)
  );

  if (HARDWIRED_ZERO) begin : g_zero
    logic unused_st;
    assign unused_st = ^stored;
    assign rd_data = '0;
  end else begin : g_live
    assign rd_data = {CODE, {MID_W{1'b0}}, stored};
  end
endmodule

// File: rtl/isa_caps_reg_chk.sv
module isa_caps_reg_chk
#(
  parameter int          XLEN           = 32,
  parameter logic [25:0] IMPL_MASK      = 26'h0,
  parameter logic [25:0] SWITCH_MASK    = 26'h0,
  parameter bit          ORDER_TSO      = 1'b0,
  parameter bit          HARDWIRED_ZERO = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [XLEN-1:0] rd_data
);
  localparam logic [25:0] RSV    = 26'h0420000;
  localparam logic [25:0] IMPL   = IMPL_MASK & ~RSV & ~26'h0080000;
  localparam bit          BOTH   = IMPL[4] & IMPL[8];
  localparam logic [25:0] FIX    = IMPL & ~SWITCH_MASK & ~26'h0010018;
  localparam logic [1:0]  CODE_V = (XLEN == 32) ? 2'd1 : ((XLEN == 64) ? 2'd2 : 2'd3);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[17] == 1'b0) && (rd_data[22] == 1'b0) && ((rd_data[25:0] & ~IMPL & ~26'h0080010) == '0)); // R3

  AST_ORDER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !HARDWIRED_ZERO |-> rd_data[19] == ORDER_TSO); // R4

  AST_BASE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (!HARDWIRED_ZERO && BOTH) |-> rd_data[4] != rd_data[8]); // R5

  AST_DEP_DF: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data[3] && !rd_data[5])); // R9

  AST_DEP_QD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data[16] && !rd_data[3])); // R10

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data)); // R8

  AST_KEEP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(rd_data[25:0] & FIX)); // R7

  AST_WIDTH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !HARDWIRED_ZERO |-> (rd_data[XLEN-1:XLEN-2] == CODE_V) && (rd_data[XLEN-3:26] == '0)); // R2

  AST_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    HARDWIRED_ZERO |-> rd_data == '0); // R11
endmodule

bind isa_caps_reg isa_caps_reg_chk #(
  .XLEN(XLEN), .IMPL_MASK(IMPL_MASK), .SWITCH_MASK(SWITCH_MASK),
  .ORDER_TSO(ORDER_TSO), .HARDWIRED_ZERO(HARDWIRED_ZERO)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data)
);

// File: tb/test_isa_caps_reg.sv
`timescale 1ns/1ps
module test_isa_caps_reg;
  localparam logic [25:0] IMPL_P = 26'h057113D;
  localparam logic [25:0] SW_P   = 26'h01F013C;
  localparam bit          TSO_P  = 1'b1;
  localparam logic [31:0] RST_EXP = 32'h401D112D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_zero;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] model_q = RST_EXP;

  always #5 clk = ~clk;

  isa_caps_reg #(.XLEN(32), .IMPL_MASK(IMPL_P), .SWITCH_MASK(SW_P),
                 .ORDER_TSO(TSO_P), .HARDWIRED_ZERO(1'b0)) i_isa_caps_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  isa_caps_reg #(.XLEN(32), .IMPL_MASK(IMPL_P), .SWITCH_MASK(SW_P),
                 .ORDER_TSO(TSO_P), .HARDWIRED_ZERO(1'b1)) i_isa_caps_reg_zero (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_zero));

  // Expected word from the requirements (R3..R10)
  function automatic logic [31:0] model(input logic [31:0] cur, input logic [31:0] d);
    logic [25:0] n;
    n = cur[25:0];
    for (int b = 0; b < 26; b++) begin
      if (SW_P[b] && IMPL_P[b] && b != 4 && b != 17 && b != 19 && b != 22) n[b] = d[b];
    end
    n[4] = ~n[8];
    if (n[3] && !n[5]) n[3] = 1'b0;
    if (n[16] && !n[3]) n[16] = 1'b0;
    n[19] = TSO_P;
    return {2'b01, 4'b0000, n};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(posedge clk);
    model_q = model(model_q, d);
    exp_q.push_back(model_q);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input logic [31:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = d;
    @(posedge clk);
    exp_q.push_back(model_q);
    tag_q.push_back(tag);
  endtask

  // Monitor: one expected item per cycle, compared away from the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, rd_data, e);
      check({t, " R11 zero build"}, rd_zero, 32'h0);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset word", rd_data, RST_EXP);
    check("R11 zero build after reset", rd_zero, 32'h0);

    idle(32'hFFFF_FFFF, "R8 idle with data ones");
    wr(32'h0000_0000, "R6 R7 R4 write zeros selects E keeps A,M");
    idle(32'h0000_0000, "R8 idle hold");
    wr(32'hFFFF_FFFF, "R2 R3 R5 write ones");
    wr(~(32'h1 << 5), "R9 F off D on clears D and Q");
    wr(~(32'h1 << 3), "R10 D off Q on clears Q");
    wr(32'hFFFF_FFFF & ~(32'h1 << 8), "R12 back-to-back I off");
    wr(32'hFFFF_FFFF, "R12 back-to-back I on");
    wr(32'h0000_0010 | (32'h1 << 19) | (32'h1 << 17), "R5 R4 R3 write E,T,rsvd only");
    wr(32'h0001_0028, "R8 switchable D,F,Q set");
    idle(32'h0000_0000, "R8 no write with zeros");
    idle(32'h0000_0000, "R1 final settle");

    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule